// File: doc/BRIEF.md
# SAR conversion sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It times an acquisition window, and then starts a conversion in one of two ways. If the start request is already low when the window closes, the conversion starts at once. Otherwise it starts when the request is first seen low. During a conversion it presents a trial code to an external DAC and comparator and takes one comparator decision per clock. The most significant bit is decided first. After the last decision it spends one more cycle latching the code into the output register. It then drops its busy flag and goes back to acquisition.

Holding the start request low gives back-to-back conversions with no further edges. A power-down input blocks conversions that have not started yet and leaves a running conversion alone. A high abort input cancels any conversion and restarts acquisition. A coding-select input chooses the output format. Straight binary passes the code unchanged. Two's complement inverts the most significant bit. Every phase length is counted in system clock cycles and is set by parameters.

Top module: `sar_conv_seq`

## Requirements
- R1: While rst_ni is low, busy_o, trial_o and result_o are all zero.
- R2: After rst_ni is released with start_i low, busy_o is first seen high exactly ACQ_CYCLES clock cycles later.
- R3: If start_i is high when acquisition ends, busy_o stays low until start_i is sampled low, and rises on that clock edge.
- R4: Every conversion that is not aborted keeps busy_o high for exactly WIDTH+1 cycles (WIDTH decision steps plus one latch cycle). With start_i held low, busy_o then stays low for exactly ACQ_CYCLES cycles before the next conversion.
- R5: In the first busy cycle trial_o has only bit WIDTH-1 set. In each step the bit under trial is kept if cmp_i is 1 and cleared if cmp_i is 0, and the next lower bit is set.
- R6: With straight_i high, the result_o loaded when busy_o falls equals the code left by the WIDTH decisions.
- R7: With straight_i low in the latch cycle, result_o is that code with bit WIDTH-1 inverted (two's complement). All other bits are unchanged.
- R8: pwrdn_i going high during a conversion neither shortens nor alters it. busy_o stays high for WIDTH+1 cycles and the result is correct.
- R9: While pwrdn_i is high, no conversion starts. Once pwrdn_i is low with start_i low and acquisition complete, busy_o rises on the next edge.
- R10: abort_i high makes busy_o low and trial_o zero on the next edge, and leaves result_o unchanged. After abort_i is released, a full ACQ_CYCLES acquisition runs again.
- R11: A low pulse on start_i that ends before acquisition completes is ignored and not queued. busy_o does not rise until start_i goes low again.
- R12: result_o changes only on the edge where busy_o falls. It stays stable throughout a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | High level cancels a conversion and restarts acquisition |
| start_i | input | 1 | Conversion request; a low level after acquisition starts a conversion |
| pwrdn_i | input | 1 | High blocks conversions not yet started |
| straight_i | input | 1 | 1 selects straight binary output, 0 selects two's complement |
| cmp_i | input | 1 | Comparator decision for the current trial code (1 = keep bit) |
| busy_o | output | 1 | High from conversion start until the result is latched |
| trial_o | output | WIDTH | Trial code sent to the DAC |
| result_o | output | WIDTH | Latched conversion result |

## Verification
The comparator is modelled as a compare against an ideal input value, so every result must reproduce that value. This catches any step that uses the wrong bit order or mishandles the extremes. The values tested include all-zeros, all-ones and mid-scale. A design that queued a start pulse seen during acquisition would raise busy too early in the start-pulse test. A design that let power-down cut a running conversion would end that conversion short or with a corrupted code. Abort in mid-conversion is checked for an immediate drop of busy, an untouched result and a full new acquisition. A controller that resumed its old counter, or latched a partial code, fails one of these checks.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CONV  = 2'd2,
    ST_LATCH = 2'd3
  } sar_state_e;

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACQ_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sar_q, sar_d;
  logic [WIDTH-1:0] ptr_q, ptr_d;  // one-hot: bit under trial

  always_comb begin
    sar_d = sar_q;
    ptr_d = ptr_q;
    if (clear_i) begin
      sar_d = '0;
      ptr_d = '0;
    end else if (load_i) begin
      sar_d = MSB;
      ptr_d = MSB;
    end else if (step_i) begin
      sar_d = (cmp_i ? sar_q : (sar_q & ~ptr_q)) | (ptr_q >> 1);
      ptr_d = ptr_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      ptr_q <= '0;
    end else begin
      sar_q <= sar_d;
      ptr_q <= ptr_d;
    end
  end

  assign trial_o = sar_q;
  assign last_o  = ptr_q[0];
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             straight_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] fmt;

  for (genvar b = 0; b < WIDTH; b++) begin : g_fmt
    if (b == WIDTH - 1) begin : g_sign
      assign fmt[b] = code_i[b] ^ ~straight_i;
    end else begin : g_pass
      assign fmt[b] = code_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_o <= '0;
    else if (load_i) result_o <= fmt;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int ACQ_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             pwrdn_i,
  input  logic             straight_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o
);
  sar_state_e state_q, state_d;
  logic acq_done, go_conv, last_step, step_en, clear_sar, latch_en;

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state_q == ST_ACQ) && !abort_i),
    .done_o (acq_done)
  );

  // start is level-sampled once acquisition is over: covers edge and held-low modes
  always_comb begin
    go_conv = 1'b0;
    if (!abort_i && !start_i && !pwrdn_i) begin
      go_conv = (state_q == ST_WAIT) || ((state_q == ST_ACQ) && acq_done);
    end
  end

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = ST_ACQ;
    end else begin
      unique case (state_q)
        ST_ACQ:   if (go_conv) state_d = ST_CONV;
                  else if (acq_done) state_d = ST_WAIT;
        ST_WAIT:  if (go_conv) state_d = ST_CONV;
        ST_CONV:  if (last_step) state_d = ST_LATCH;
        ST_LATCH: state_d = ST_ACQ;
        default:  state_d = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACQ;
    else         state_q <= state_d;
  end

  assign step_en   = (state_q == ST_CONV) && !abort_i;
  assign latch_en  = (state_q == ST_LATCH) && !abort_i;
  assign clear_sar = abort_i || (state_q == ST_LATCH);

  sar_step_engine #(.WIDTH(WIDTH)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_sar),
    .load_i  (go_conv),
    .step_i  (step_en),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .last_o  (last_step)
  );

  sar_result_reg #(.WIDTH(WIDTH)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (latch_en),
    .straight_i (straight_i),
    .code_i     (trial_o),
    .result_o   (result_o)
  );

  assign busy_o = (state_q == ST_CONV) || (state_q == ST_LATCH);
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             abort_i,
  input logic             pwrdn_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] trial_o,
  input logic [WIDTH-1:0] result_o
);
  localparam int CW = $clog2(WIDTH + 3);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R4 and R8: an unaborted conversion is never cut short by power-down
  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(abort_i)) |-> (busy_cnt == CW'(WIDTH + 1)));

  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (trial_o == MSB));

  assert_pd_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(pwrdn_i));

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && (trial_o == '0) && $stable(result_o)));

  assert_result_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(result_o));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .abort_i  (abort_i),
  .pwrdn_i  (pwrdn_i),
  .busy_o   (busy_o),
  .trial_o  (trial_o),
  .result_o (result_o)
);

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  localparam int W   = 16;
  localparam int ACQ = 8;
  localparam logic [W-1:0] MSB = 16'h8000;

  // {analog value, straight, expected result}
  localparam logic [32:0] VEC [8] = '{
    {16'h1234, 1'b1, 16'h1234},
    {16'h0000, 1'b1, 16'h0000},
    {16'hFFFF, 1'b1, 16'hFFFF},
    {16'h8000, 1'b0, 16'h0000},
    {16'h1234, 1'b0, 16'h9234},
    {16'h7FFF, 1'b0, 16'hFFFF},
    {16'hA5A5, 1'b1, 16'hA5A5},
    {16'h0001, 1'b0, 16'h8001}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic abort_i = 1'b0, start_i = 1'b1, pwrdn_i = 1'b0, straight_i = 1'b1;
  logic [W-1:0] x_val = '0;
  logic cmp_i, busy_o;
  logic [W-1:0] trial_o, result_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign cmp_i = (trial_o <= x_val);

  sar_conv_seq #(.WIDTH(W), .ACQ_CYCLES(ACQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .abort_i(abort_i), .start_i(start_i),
    .pwrdn_i(pwrdn_i), .straight_i(straight_i), .cmp_i(cmp_i),
    .busy_o(busy_o), .trial_o(trial_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy_o !== lvl && n < 500);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] prev;
    logic seen;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy", 32'(busy_o), 0);
    chk(trial_o === '0, "R1 trial", 32'(trial_o), 0);
    chk(result_o === '0, "R1 result", 32'(result_o), 0);

    rst_ni = 1'b1;
    start_i = 1'b0;
    prev = '0;
    for (int i = 0; i < 8; i++) begin
      x_val = VEC[i][32:17];
      straight_i = VEC[i][16];
      wait_busy(1'b1, n);
      if (i == 0) chk(n == ACQ, "R2 acquisition length", 32'(n), ACQ);
      else        chk(n == ACQ, "R4 idle gap", 32'(n), ACQ);
      chk(trial_o === MSB, "R5 first trial", 32'(trial_o), 32'(MSB));
      chk(result_o === prev, "R12 result held", 32'(result_o), 32'(prev));
      @(negedge clk);
      chk(trial_o === ((x_val & MSB) | 16'h4000), "R5 second trial", 32'(trial_o),
          32'((x_val & MSB) | 16'h4000));
      wait_busy(1'b0, n);
      chk(n + 1 == W + 1, "R4 busy length", 32'(n + 1), W + 1);
      if (VEC[i][16]) chk(result_o === VEC[i][15:0], "R6 straight result", 32'(result_o), 32'(VEC[i][15:0]));
      else            chk(result_o === VEC[i][15:0], "R7 twos complement", 32'(result_o), 32'(VEC[i][15:0]));
      prev = VEC[i][15:0];
    end

    // R11: short start pulse during acquisition is not queued
    start_i = 1'b1;
    repeat (2) @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    seen = 1'b0;
    repeat (ACQ + 4) begin
      @(negedge clk);
      if (busy_o) seen = 1'b1;
    end
    chk(!seen, "R11 pulse ignored", 32'(seen), 0);
    x_val = 16'h4321;
    straight_i = 1'b1;
    start_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b1, "R3 start on low", 32'(busy_o), 1);
    wait_busy(1'b0, n);
    chk(result_o === 16'h4321, "R6 edge-mode result", 32'(result_o), 32'h4321);

    // R9: power-down blocks a start
    pwrdn_i = 1'b1;
    seen = 1'b0;
    repeat (2 * ACQ) begin
      @(negedge clk);
      if (busy_o) seen = 1'b1;
    end
    chk(!seen, "R9 no start in power-down", 32'(seen), 0);
    pwrdn_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b1, "R9 start after release", 32'(busy_o), 1);
    // R8: power-down during conversion has no effect
    pwrdn_i = 1'b1;
    wait_busy(1'b0, n);
    chk(n == W + 1, "R8 full length", 32'(n), W + 1);
    chk(result_o === 16'h4321, "R8 result intact", 32'(result_o), 32'h4321);
    pwrdn_i = 1'b0;

    // R10: abort mid-conversion
    x_val = 16'h0F0F;
    wait_busy(1'b1, n);
    repeat (4) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R10 busy dropped", 32'(busy_o), 0);
    chk(trial_o === '0, "R10 trial cleared", 32'(trial_o), 0);
    chk(result_o === 16'h4321, "R10 result kept", 32'(result_o), 32'h4321);
    repeat (3) @(negedge clk);
    abort_i = 1'b0;
    wait_busy(1'b1, n);
    chk(n == ACQ, "R10 full reacquisition", 32'(n), ACQ);
    wait_busy(1'b0, n);
    chk(result_o === 16'h0F0F, "R6 result after abort", 32'(result_o), 32'h0F0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule